// File: doc/BRIEF.md
# AES Table-Lookup Column Round Unit

This block produces one column of a middle AES encryption round. Byte substitution, column mixing and round-key addition are folded into four precomputed 256-entry by 32-bit lookup tables. Each table holds the S-box output of a byte already multiplied by one column of the mixing matrix, so at run time a column costs four lookups and one XOR of five words. No finite-field arithmetic runs in the datapath.

The four tables sit in two dual-port memories. Each memory serves two tables, one per port, and both ports are read in the same cycle. The memory contents are computed by package functions when the design is elaborated. The caller supplies a column that has already been row-shifted, together with its round key word. A new column may be presented on every clock. The result appears two cycles later with its own valid strobe. Byte row 0 of every 32-bit word sits in bits [31:24], and rows 1, 2 and 3 follow in the lower bytes.

Top module: `aes_col_round`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `out_valid` is 0.
- R2: `out_valid` is 1 exactly two clock cycles after a cycle in which `in_valid` was 1, and 0 otherwise.
- R3: A column is accepted on every cycle that `in_valid` is 1, including back-to-back cycles, and each one yields its own correct result.
- R4: For a valid column with bytes a0..a3 (a0 in bits [31:24]), `out_col` equals the AES column mix (rows 02 03 01 01, 01 02 03 01, 01 01 02 03, 03 01 01 02 over GF(2^8) with polynomial 0x11B) of S(a0)..S(a3), XORed with `in_key`. Row 0 of the result is in bits [31:24].
- R5: The substitution is the standard AES forward S-box. An all-0x00 column with a zero key gives 0x63636363, and an all-0x53 column with a zero key gives 0xEDEDEDED.
- R6: `in_key` is XORed bitwise into the result. An all-zero column with key 0xFFFFFFFF gives 0x9C9C9C9C.
- R7: When a cycle carries no valid column, `out_col` keeps the last valid result two cycles later.
- R8: Each table read returns the table word for the addressed byte. A column with a single nonzero byte in row r gives that table's rotated pattern XORed with the constant contribution of S(0) from the other three rows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the valid pipeline |
| in_valid | input | 1 | The column and key on this cycle are to be processed |
| in_col | input | 32 | Input column, row 0 in bits [31:24] |
| in_key | input | 32 | Round key word for this column |
| out_valid | output | 1 | `out_col` holds a new result |
| out_col | output | 32 | Result column, row 0 in bits [31:24] |

## Verification
A wrong table entry shows up as a corrupted output column two cycles after the first column that addresses that byte. Because the bench sweeps many random bytes through all four rows, a single bad word in any of the 1024 table entries is likely to surface within a few hundred columns. A broken valid pipeline shows as a strobe one cycle early or late, or a result that changes during an idle cycle, on the very next column. A swapped table rotation or byte lane corrupts almost every result from the first non-uniform column.

// File: rtl/aes_col_pkg.sv
package aes_col_pkg;
  localparam int BYTE_W    = 8;
  localparam int NUM_ROWS  = 4;
  localparam int COL_W     = BYTE_W * NUM_ROWS;
  localparam int TBL_DEPTH = 1 << BYTE_W;
  localparam int NUM_RAMS  = NUM_ROWS / 2;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [COL_W-1:0]  col_t;

  // multiply by x modulo x^8+x^4+x^3+x+1
  function automatic byte_t gf_xtime(input byte_t b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1B : 8'h00);
  endfunction

  function automatic byte_t gf_mul(input byte_t a, input byte_t b);
    byte_t acc = '0;
    byte_t sh  = a;
    for (int k = 0; k < BYTE_W; k++) begin
      if (b[k]) acc = acc ^ sh;
      sh = gf_xtime(sh);
    end
    return acc;
  endfunction

  // inverse as a^254 by square-and-multiply; maps 0 to 0
  function automatic byte_t gf_inv(input byte_t a);
    byte_t r = 8'h01;
    byte_t base = a;
    logic [7:0] e = 8'd254;
    for (int k = 0; k < BYTE_W; k++) begin
      if (e[k]) r = gf_mul(r, base);
      base = gf_mul(base, base);
    end
    return r;
  endfunction

  function automatic byte_t rotl8(input byte_t b, input int n);
    byte_t r = b;
    for (int k = 0; k < n; k++) r = {r[6:0], r[7]};
    return r;
  endfunction

  function automatic byte_t sbox_fwd(input byte_t a);
    byte_t v = gf_inv(a);
    return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
  endfunction

  // table word for table index idx: base pattern rotated right by idx bytes
  function automatic col_t tbl_word(input logic [1:0] idx, input byte_t a);
    byte_t s  = sbox_fwd(a);
    byte_t s2 = gf_xtime(s);
    byte_t s3 = s2 ^ s;
    col_t  w  = {s2, s, s, s3};
    col_t  r  = w;
    for (int k = 0; k < NUM_ROWS; k++)
      if (k < int'(idx)) r = {r[BYTE_W-1:0], r[COL_W-1:BYTE_W]};
    return r;
  endfunction
endpackage

// File: rtl/aes_col_tbl_ram.sv
module aes_col_tbl_ram
  import aes_col_pkg::*;
#(
  parameter int TBL_LO = 0,
  parameter int TBL_HI = 1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rd_en,
  input  byte_t addr_a,
  input  byte_t addr_b,
  output col_t  q_a,
  output col_t  q_b
);
  localparam int DEPTH  = 2 * TBL_DEPTH;
  localparam int ADDR_W = $clog2(DEPTH);

  col_t mem [DEPTH];

  initial begin
    for (int i = 0; i < TBL_DEPTH; i++) begin
      mem[ADDR_W'(i)]             = tbl_word(2'(TBL_LO), byte_t'(i));
      mem[ADDR_W'(i + TBL_DEPTH)] = tbl_word(2'(TBL_HI), byte_t'(i));
    end
  end

  logic [ADDR_W-1:0] ptr_a, ptr_b;
  assign ptr_a = {1'b0, addr_a};
  assign ptr_b = {1'b1, addr_b};

  always_ff @(posedge clk) begin
    if (rd_en) begin
      q_a <= mem[ptr_a];
      q_b <= mem[ptr_b];
    end
  end

  // R8
  tbl_port_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> q_a == tbl_word(2'(TBL_LO), $past(addr_a)));
  // R8
  tbl_port_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> q_b == tbl_word(2'(TBL_HI), $past(addr_b)));
endmodule

// File: rtl/aes_col_xor5.sv
module aes_col_xor5
  import aes_col_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic s1_valid,
  input  col_t tbl_q [NUM_ROWS],
  input  col_t key_q,
  output logic out_valid,
  output col_t out_col
);
  col_t mix_sum;

  always_comb begin
    mix_sum = key_q;
    for (int r = 0; r < NUM_ROWS; r++) mix_sum = mix_sum ^ tbl_q[r];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= s1_valid;
  end

  always_ff @(posedge clk) begin
    if (s1_valid) out_col <= mix_sum;
  end

  // R7
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> $stable(out_col));
  // R2
  out_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> out_valid);
endmodule

// File: rtl/aes_col_round.sv
module aes_col_round
  import aes_col_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_col,
  input  logic [31:0] in_key,
  output logic        out_valid,
  output logic [31:0] out_col
);
  byte_t in_byte [NUM_ROWS];
  col_t  tbl_q   [NUM_ROWS];
  col_t  key_q;
  logic  s1_valid;

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_lane
    assign in_byte[r] = in_col[COL_W-1-BYTE_W*r -: BYTE_W];
  end

  for (genvar m = 0; m < NUM_RAMS; m++) begin : g_ram
    aes_col_tbl_ram #(.TBL_LO(2*m), .TBL_HI(2*m+1)) u_ram (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_en  (in_valid),
      .addr_a (in_byte[2*m]),
      .addr_b (in_byte[2*m+1]),
      .q_a    (tbl_q[2*m]),
      .q_b    (tbl_q[2*m+1])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) s1_valid <= 1'b0;
    else        s1_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) key_q <= in_key;
  end

  aes_col_xor5 u_xor (
    .clk       (clk),
    .rst_n     (rst_n),
    .s1_valid  (s1_valid),
    .tbl_q     (tbl_q),
    .key_q     (key_q),
    .out_valid (out_valid),
    .out_col   (out_col)
  );

  // R2
  stage1_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> s1_valid);
  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> !out_valid);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

// File: tb/aes_col_round_bench.sv
`timescale 1ns/1ps
module aes_col_round_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_col = '0;
  logic [31:0] in_key = '0;
  logic        out_valid;
  logic [31:0] out_col;

  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk = ~clk;

  aes_col_round u_aes_col_round (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_col(in_col), .in_key(in_key),
    .out_valid(out_valid), .out_col(out_col)
  );

  function automatic logic [7:0] m2(input logic [7:0] b);
    return b[7] ? ((b << 1) ^ 8'h1B) : (b << 1);
  endfunction

  function automatic logic [7:0] mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 0;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= x;
      x = m2(x);
    end
    return p;
  endfunction

  function automatic logic [7:0] sb(input logic [7:0] a);
    logic [7:0] inv = 0;
    logic [7:0] c = 8'h63;
    logic [7:0] s;
    for (int j = 1; j < 256; j++)
      if (mul(a, 8'(j)) == 8'h01) inv = 8'(j);
    for (int i = 0; i < 8; i++)
      s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ c[i];
    return s;
  endfunction

  function automatic logic [31:0] model(input logic [31:0] c, input logic [31:0] k);
    logic [7:0] s0, s1, s2, s3, b0, b1, b2, b3;
    s0 = sb(c[31:24]); s1 = sb(c[23:16]); s2 = sb(c[15:8]); s3 = sb(c[7:0]);
    b0 = m2(s0) ^ (m2(s1) ^ s1) ^ s2 ^ s3;
    b1 = s0 ^ m2(s1) ^ (m2(s2) ^ s2) ^ s3;
    b2 = s0 ^ s1 ^ m2(s2) ^ (m2(s3) ^ s3);
    b3 = (m2(s0) ^ s0) ^ s1 ^ s2 ^ m2(s3);
    return {b0, b1, b2, b3} ^ k;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic        p1_v = 0, p2_v = 0;
  logic [31:0] p1_e, p2_e;
  string       p1_t = "", p2_t = "";
  logic [31:0] last_out;
  bit          have_last = 0;

  // one cycle: check the column issued two cycles ago, then drive the next
  task automatic step(input bit v, input logic [31:0] c, input logic [31:0] k,
                      input string tag, input logic [31:0] exp_over, input bit use_over);
    @(negedge clk);
    if (p2_v) begin
      check("R2 valid", {31'b0, out_valid}, 32'd1);
      check(p2_t, out_col, p2_e);
      last_out = p2_e;
      have_last = 1;
    end else begin
      check("R2 idle", {31'b0, out_valid}, 32'd0);
      if (have_last) check("R7 hold", out_col, last_out);
    end
    p2_v = p1_v; p2_e = p1_e; p2_t = p1_t;
    p1_v = v;    p1_e = use_over ? exp_over : model(c, k); p1_t = tag;
    in_valid = v; in_col = c; in_key = k;
  endtask

  initial begin
    #500_000ns;
    n_errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    int unsigned dummy;
    dummy = $urandom(32'h00C0FFEE);
    repeat (3) @(negedge clk);
    check("R1 in reset", {31'b0, out_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {31'b0, out_valid}, 32'd0);

    step(1, 32'h00000000, 32'h0, "R5 zero column", 32'h63636363, 1);
    step(1, 32'h53535353, 32'h0, "R5 0x53 column", 32'hEDEDEDED, 1);
    step(1, 32'h00000000, 32'hFFFFFFFF, "R6 key all ones", 32'h9C9C9C9C, 1);
    step(1, 32'h00000000, 32'hA5A5A5A5, "R6 key pattern", 32'h63636363 ^ 32'hA5A5A5A5, 1);
    for (int r = 0; r < 4; r++)
      for (int b = 1; b < 256; b += 37)
        step(1, 32'(b) << (8*(3-r)), 32'h0, "R8 single row byte", 0, 0);
    repeat (3) step(0, $urandom, $urandom, "R7 idle", 0, 0);
    step(1, 32'hDB135345, 32'h01020304, "R4 directed", 0, 0);
    step(0, $urandom, $urandom, "R7 idle", 0, 0);
    step(0, $urandom, $urandom, "R7 idle", 0, 0);
    step(0, $urandom, $urandom, "R7 idle", 0, 0);
    for (int i = 0; i < 1500; i++)
      step(1, $urandom, $urandom, "R3 back-to-back", 0, 0);
    for (int i = 0; i < 1500; i++) begin
      bit v = ($urandom % 3) != 0;
      step(v, $urandom, $urandom, "R4 random", 0, 0);
    end
    repeat (3) step(0, 32'h0, 32'h0, "R7 flush", 0, 0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule